// File: doc/BRIEF.md
# Four-Bit Dual-Mode Arithmetic Logic Unit

This block is a purely combinational four-bit arithmetic logic unit. A four-bit function code and a mode bit together pick one of thirty-two operations on two four-bit operands. With the mode bit low, the unit forms one operand term and a second addend term from the inputs and adds them with the incoming carry. With the mode bit high, it applies a bitwise two-input function and ignores the incoming carry.

Beside the four-bit result, the unit drives a carry output and an all-ones flag. The all-ones flag is an equality test when the subtract code is used with no incoming carry. It also drives group propagate and group generate signals, so a wider word can be built from several units around an external look-ahead carry unit. The design is split into a code decoder, which drives a small control struct, and a datapath. A thin top module instantiates both.

Top module: `alu4`

## Requirements
- R1: With logicMode=0, the arithmetic result is U + V + carryIn modulo 16. For six codes, U and V are: fnSel=4'b0000: A + 4'b1111 (A minus one); 4'b0110: A + ~B (A minus B minus one); 4'b1001: A + B; 4'b1011: (A|B) + 0; 4'b1100: A + A; 4'b1111: A + 0.
- R2: With logicMode=1, result is bitwise: 4'b0000 gives ~A, 4'b0110 gives ~(A^B), 4'b1001 gives A^B, 4'b1011 gives A|B, 4'b1100 gives 4'b0000, and 4'b1111 gives A.
- R3: The other ten codes in arithmetic mode use these U + V pairs: 4'b0001 (A|B)+4'b1111; 4'b0010 (A|~B)+4'b1111; 4'b0011 0+4'b1111; 4'b0100 A+(A&~B); 4'b0101 (A|B)+(A&~B); 4'b0111 (A&~B)+4'b1111; 4'b1000 A+(A&B); 4'b1010 (A|~B)+(A&B); 4'b1101 (A|B)+A; 4'b1110 (A|~B)+A.
- R4: The other ten codes in logic mode give: 4'b0001 ~(A|B); 4'b0010 ~A&B; 4'b0011 4'b1111; 4'b0100 ~(A&B); 4'b0101 ~B; 4'b0111 A&~B; 4'b1000 ~A|B; 4'b1010 B; 4'b1101 A|~B; 4'b1110 A&B.
- R5: With logicMode=0, carryOut is the carry out of bit 3 of U + V + carryIn.
- R6: With logicMode=1, carryOut is 0, and neither result nor carryOut changes when carryIn changes.
- R7: allOnes is 1 exactly when result equals 4'b1111. With fnSel=4'b0110, logicMode=0 and carryIn=0, this means A equals B.
- R8: grpProp is 1 exactly when U^V equals 4'b1111. grpGen is the carry out of U + V with no incoming carry. Both follow the arithmetic U and V for the code in either mode, and in arithmetic mode carryOut equals grpGen | (grpProp & carryIn).
- R9: For every known input combination, all outputs are known (no X).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 4 | First operand |
| opB | input | 4 | Second operand |
| fnSel | input | 4 | Function code |
| logicMode | input | 1 | 0 selects arithmetic, 1 selects bitwise logic |
| carryIn | input | 1 | Incoming carry, active high |
| result | output | 4 | Function result |
| carryOut | output | 1 | Carry out of the top bit (0 in logic mode) |
| allOnes | output | 1 | Result is all ones |
| grpProp | output | 1 | Group propagate |
| grpGen | output | 1 | Group generate |

## Verification
Every code is applied in both modes over all 256 operand pairs and both carry values. The six listed codes are checked apart from the ten filled-in ones, so an error in one half of the decode table is reported against its own requirement. In logic mode, each operand pair is applied twice, differing only in carryIn, to show that the carry has no effect. Equal and unequal operand pairs under the subtract code separate a true equality flag from a flag that fires on other results. The group outputs are compared with operand pairs that propagate, generate or kill, and the look-ahead identity is checked against the ripple carry.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [2:0] {
    U_ZERO,
    U_A,
    U_A_OR_B,
    U_A_OR_NB,
    U_A_AND_NB
  } uSel_e;

  typedef enum logic [2:0] {
    V_ZERO,
    V_ONES,
    V_B,
    V_NB,
    V_A,
    V_A_AND_B,
    V_A_AND_NB
  } vSel_e;

  // Strobes from the decoder to the datapath.
  // logicLut is indexed by {aBit, bBit}.
  typedef struct packed {
    uSel_e      uSel;
    vSel_e      vSel;
    logic [3:0] logicLut;
    logic       arithEn;
  } aluCtrl_t;

endpackage

// File: rtl/alu4_ctrl.sv
module alu4_ctrl
  import alu4_pkg::*;
(
  input  logic [3:0] fnSel,
  input  logic       logicMode,
  output aluCtrl_t   ctrl
);

  localparam logic [3:0] LUT_NOT_A   = 4'b0011;
  localparam logic [3:0] LUT_NOR     = 4'b0001;
  localparam logic [3:0] LUT_NA_B    = 4'b0010;
  localparam logic [3:0] LUT_ONES    = 4'b1111;
  localparam logic [3:0] LUT_NAND    = 4'b0111;
  localparam logic [3:0] LUT_NOT_B   = 4'b0101;
  localparam logic [3:0] LUT_XNOR    = 4'b1001;
  localparam logic [3:0] LUT_A_NB    = 4'b0100;
  localparam logic [3:0] LUT_NA_OR_B = 4'b1011;
  localparam logic [3:0] LUT_XOR     = 4'b0110;
  localparam logic [3:0] LUT_B       = 4'b1010;
  localparam logic [3:0] LUT_OR      = 4'b1110;
  localparam logic [3:0] LUT_ZERO    = 4'b0000;
  localparam logic [3:0] LUT_A_OR_NB = 4'b1101;
  localparam logic [3:0] LUT_AND     = 4'b1000;
  localparam logic [3:0] LUT_A       = 4'b1100;

  always_comb begin
    ctrl.arithEn = ~logicMode;
    case (fnSel)
      4'b0000: begin ctrl.uSel = U_A;        ctrl.vSel = V_ONES;     ctrl.logicLut = LUT_NOT_A;   end
      4'b0001: begin ctrl.uSel = U_A_OR_B;   ctrl.vSel = V_ONES;     ctrl.logicLut = LUT_NOR;     end
      4'b0010: begin ctrl.uSel = U_A_OR_NB;  ctrl.vSel = V_ONES;     ctrl.logicLut = LUT_NA_B;    end
      4'b0011: begin ctrl.uSel = U_ZERO;     ctrl.vSel = V_ONES;     ctrl.logicLut = LUT_ONES;    end
      4'b0100: begin ctrl.uSel = U_A;        ctrl.vSel = V_A_AND_NB; ctrl.logicLut = LUT_NAND;    end
      4'b0101: begin ctrl.uSel = U_A_OR_B;   ctrl.vSel = V_A_AND_NB; ctrl.logicLut = LUT_NOT_B;   end
      4'b0110: begin ctrl.uSel = U_A;        ctrl.vSel = V_NB;       ctrl.logicLut = LUT_XNOR;    end
      4'b0111: begin ctrl.uSel = U_A_AND_NB; ctrl.vSel = V_ONES;     ctrl.logicLut = LUT_A_NB;    end
      4'b1000: begin ctrl.uSel = U_A;        ctrl.vSel = V_A_AND_B;  ctrl.logicLut = LUT_NA_OR_B; end
      4'b1001: begin ctrl.uSel = U_A;        ctrl.vSel = V_B;        ctrl.logicLut = LUT_XOR;     end
      4'b1010: begin ctrl.uSel = U_A_OR_NB;  ctrl.vSel = V_A_AND_B;  ctrl.logicLut = LUT_B;       end
      4'b1011: begin ctrl.uSel = U_A_OR_B;   ctrl.vSel = V_ZERO;     ctrl.logicLut = LUT_OR;      end
      4'b1100: begin ctrl.uSel = U_A;        ctrl.vSel = V_A;        ctrl.logicLut = LUT_ZERO;    end
      4'b1101: begin ctrl.uSel = U_A_OR_B;   ctrl.vSel = V_A;        ctrl.logicLut = LUT_A_OR_NB; end
      4'b1110: begin ctrl.uSel = U_A_OR_NB;  ctrl.vSel = V_A;        ctrl.logicLut = LUT_AND;     end
      default: begin ctrl.uSel = U_A;        ctrl.vSel = V_ZERO;     ctrl.logicLut = LUT_A;       end
    endcase
  end

  always_comb begin
    if (!$isunknown({fnSel, logicMode}))
      AST_CTRL_KNOWN: assert (!$isunknown(ctrl)); // R9
  end

endmodule

// File: rtl/alu4_dp.sv
module alu4_dp
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  aluCtrl_t         ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             grpProp,
  output logic             grpGen
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] uTerm;
  logic [WIDTH-1:0] vTerm;
  logic [WIDTH-1:0] sumVec;
  logic [WIDTH-1:0] logicVec;
  logic [WIDTH:0]   rippleC;
  logic [WIDTH:0]   genC;

  always_comb begin
    case (ctrl.uSel)
      U_ZERO:     uTerm = '0;
      U_A:        uTerm = opA;
      U_A_OR_B:   uTerm = opA | opB;
      U_A_OR_NB:  uTerm = opA | ~opB;
      U_A_AND_NB: uTerm = opA & ~opB;
      default:    uTerm = opA;
    endcase
  end

  always_comb begin
    case (ctrl.vSel)
      V_ZERO:     vTerm = '0;
      V_ONES:     vTerm = ALL_ONES;
      V_B:        vTerm = opB;
      V_NB:       vTerm = ~opB;
      V_A:        vTerm = opA;
      V_A_AND_B:  vTerm = opA & opB;
      V_A_AND_NB: vTerm = opA & ~opB;
      default:    vTerm = '0;
    endcase
  end

  assign rippleC[0] = carryIn;
  assign genC[0]    = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic pBit;
    logic gBit;
    assign pBit         = uTerm[i] ^ vTerm[i];
    assign gBit         = uTerm[i] & vTerm[i];
    assign sumVec[i]    = pBit ^ rippleC[i];
    assign rippleC[i+1] = gBit | (pBit & rippleC[i]);
    assign genC[i+1]    = gBit | (pBit & genC[i]);
    assign logicVec[i]  = ctrl.logicLut[{opA[i], opB[i]}];
  end

  assign grpProp  = &(uTerm ^ vTerm);
  assign grpGen   = genC[WIDTH];
  assign result   = ctrl.arithEn ? sumVec : logicVec;
  assign carryOut = ctrl.arithEn & rippleC[WIDTH];

  always_comb begin
    if (!$isunknown({opA, opB, carryIn, ctrl})) begin
      if (ctrl.arithEn)
        AST_CARRY_LOOKAHEAD: assert (carryOut == (grpGen | (grpProp & carryIn))); // R8
      AST_PG_EXCLUSIVE: assert (!(grpProp && grpGen)); // R8
    end
  end

endmodule

// File: rtl/alu4.sv
module alu4
  import alu4_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       fnSel,
  input  logic             logicMode,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             allOnes,
  output logic             grpProp,
  output logic             grpGen
);

  aluCtrl_t ctrl;

  alu4_ctrl u_ctrl (
    .fnSel    (fnSel),
    .logicMode(logicMode),
    .ctrl     (ctrl)
  );

  alu4_dp #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .ctrl    (ctrl),
    .result  (result),
    .carryOut(carryOut),
    .grpProp (grpProp),
    .grpGen  (grpGen)
  );

  assign allOnes = &result;

  always_comb begin
    if (!$isunknown({opA, opB, fnSel, logicMode, carryIn})) begin
      if (fnSel == 4'b0110 && !logicMode && !carryIn && opA == opB)
        AST_SUB_EQUAL: assert (allOnes); // R7
      if (logicMode)
        AST_LOGIC_NO_CARRY: assert (!carryOut); // R6
    end
  end

endmodule

// File: tb/alu4_tb.sv
module alu4_tb;

  logic       clk = 1'b0;
  logic [3:0] opA = '0, opB = '0, fnSel = '0;
  logic       logicMode = 1'b0, carryIn = 1'b0;
  logic [3:0] result;
  logic       carryOut, allOnes, grpProp, grpGen;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  alu4 u_dut (
    .opA(opA), .opB(opB), .fnSel(fnSel), .logicMode(logicMode),
    .carryIn(carryIn), .result(result), .carryOut(carryOut),
    .allOnes(allOnes), .grpProp(grpProp), .grpGen(grpGen)
  );

  // Arithmetic terms taken from R1 and R3: returns {U, V}.
  function automatic logic [7:0] refUV(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      4'b0000: return {a,       4'hF};
      4'b0001: return {a | b,   4'hF};
      4'b0010: return {a | ~b,  4'hF};
      4'b0011: return {4'h0,    4'hF};
      4'b0100: return {a,       a & ~b};
      4'b0101: return {a | b,   a & ~b};
      4'b0110: return {a,       ~b};
      4'b0111: return {a & ~b,  4'hF};
      4'b1000: return {a,       a & b};
      4'b1001: return {a,       b};
      4'b1010: return {a | ~b,  a & b};
      4'b1011: return {a | b,   4'h0};
      4'b1100: return {a,       a};
      4'b1101: return {a | b,   a};
      4'b1110: return {a | ~b,  a};
      default: return {a,       4'h0};
    endcase
  endfunction

  // Bitwise results from R2 and R4.
  function automatic logic [3:0] refLogic(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      4'b0000: return ~a;
      4'b0001: return ~(a | b);
      4'b0010: return ~a & b;
      4'b0011: return 4'hF;
      4'b0100: return ~(a & b);
      4'b0101: return ~b;
      4'b0110: return ~(a ^ b);
      4'b0111: return a & ~b;
      4'b1000: return ~a | b;
      4'b1001: return a ^ b;
      4'b1010: return b;
      4'b1011: return a | b;
      4'b1100: return 4'h0;
      4'b1101: return a | ~b;
      4'b1110: return a & b;
      default: return a;
    endcase
  endfunction

  function automatic bit isListed(input logic [3:0] s);
    return s == 4'b0000 || s == 4'b0110 || s == 4'b1001 ||
           s == 4'b1011 || s == 4'b1100 || s == 4'b1111;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s sel=%b m=%b a=%h b=%h cin=%b actual=%h expected=%h",
               tag, fnSel, logicMode, opA, opB, carryIn, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic m, input logic [3:0] a,
                       input logic [3:0] b, input logic c);
    @(negedge clk);
    fnSel = s; logicMode = m; opA = a; opB = b; carryIn = c;
    #1;
  endtask

  // Arithmetic check of result and carry (R1/R3 and R5).
  task automatic checkArith(input string tag);
    logic [7:0] uv;
    logic [4:0] sum;
    uv  = refUV(fnSel, opA, opB);
    sum = {1'b0, uv[7:4]} + {1'b0, uv[3:0]} + {4'b0, carryIn};
    check(tag, {4'h0, result}, {4'h0, sum[3:0]});
    check("R5 carryOut", {7'h0, carryOut}, {7'h0, sum[4]});
  endtask

  task automatic testResetState();
    apply(4'b0000, 1'b0, 4'h0, 4'h0, 1'b0);
    check("R1 zero inputs result", {4'h0, result}, 8'h0F);
    check("R5 zero inputs carry", {7'h0, carryOut}, 8'h00);
    check("R7 zero inputs allOnes", {7'h0, allOnes}, 8'h01);
  endtask

  task automatic testListedArith();
    for (int s = 0; s < 16; s++)
      if (isListed(4'(s)))
        for (int v = 0; v < 512; v++) begin
          apply(4'(s), 1'b0, v[3:0], v[7:4], v[8]);
          checkArith("R1 listed arithmetic");
        end
  endtask

  task automatic testListedLogic();
    for (int s = 0; s < 16; s++)
      if (isListed(4'(s)))
        for (int v = 0; v < 256; v++) begin
          apply(4'(s), 1'b1, v[3:0], v[7:4], 1'b0);
          check("R2 listed logic", {4'h0, result}, {4'h0, refLogic(fnSel, opA, opB)});
        end
  endtask

  task automatic testOtherCodes();
    for (int s = 0; s < 16; s++)
      if (!isListed(4'(s)))
        for (int v = 0; v < 512; v++) begin
          apply(4'(s), 1'b0, v[3:0], v[7:4], v[8]);
          checkArith("R3 filled arithmetic");
          apply(4'(s), 1'b1, v[3:0], v[7:4], v[8]);
          check("R4 filled logic", {4'h0, result}, {4'h0, refLogic(fnSel, opA, opB)});
        end
  endtask

  task automatic testCarryIgnored();
    logic [3:0] r0;
    logic       c0;
    for (int s = 0; s < 16; s++)
      for (int v = 0; v < 256; v++) begin
        apply(4'(s), 1'b1, v[3:0], v[7:4], 1'b0);
        r0 = result; c0 = carryOut;
        check("R6 logic carryOut zero", {7'h0, c0}, 8'h00);
        apply(4'(s), 1'b1, v[3:0], v[7:4], 1'b1);
        check("R6 carryIn no effect result", {4'h0, result}, {4'h0, r0});
        check("R6 carryIn no effect carry", {7'h0, carryOut}, {7'h0, c0});
      end
  endtask

  task automatic testEqualFlag();
    for (int v = 0; v < 256; v++) begin
      apply(4'b0110, 1'b0, v[3:0], v[7:4], 1'b0);
      check("R7 subtract equality", {7'h0, allOnes}, {7'h0, (v[3:0] == v[7:4])});
    end
    for (int s = 0; s < 16; s++)
      for (int v = 0; v < 256; v++) begin
        apply(4'(s), v[0], v[3:0], v[7:4], v[1]);
        check("R7 allOnes tracks result", {7'h0, allOnes}, {7'h0, (result == 4'hF)});
      end
  endtask

  task automatic testGroup();
    logic [7:0] uv;
    logic [4:0] raw;
    for (int s = 0; s < 16; s++)
      for (int v = 0; v < 1024; v++) begin
        apply(4'(s), v[9], v[3:0], v[7:4], v[8]);
        uv  = refUV(fnSel, opA, opB);
        raw = {1'b0, uv[7:4]} + {1'b0, uv[3:0]};
        check("R8 grpProp", {7'h0, grpProp}, {7'h0, ((uv[7:4] ^ uv[3:0]) == 4'hF)});
        check("R8 grpGen", {7'h0, grpGen}, {7'h0, raw[4]});
        if (!logicMode)
          check("R8 lookahead identity", {7'h0, carryOut},
                {7'h0, (grpGen | (grpProp & carryIn))});
      end
  endtask

  task automatic testNoX();
    for (int s = 0; s < 16; s++)
      for (int v = 0; v < 16; v++) begin
        apply(4'(s), v[0], {v[3:1], 1'b1}, {v[1:0], v[3:2]}, v[2]);
        check("R9 outputs known",
              {7'h0, $isunknown({result, carryOut, allOnes, grpProp, grpGen})}, 8'h00);
      end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    testResetState();
    testListedArith();
    testListedLogic();
    testOtherCodes();
    testCarryIgnored();
    testEqualFlag();
    testGroup();
    testNoX();
    done = 1'b1;
  end

  initial begin
    for (int cyc = 0; cyc < 190000; cyc++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule